// File: doc/BRIEF.md
# Interleaved Converter Result Packer

This block sits behind two or three time-interleaved analog-to-digital converters that run at 8-bit or 6-bit resolution. The converters finish in a fixed rotation: first, second, then, in triple mode, third. The block takes results in that order, holds the first result of each pair and packs it with the next result into a 16-bit common data word. The earlier result goes in the low byte and the later one in the high byte. Each packed word raises a request towards a DMA engine, and the request stays high until the engine acknowledges it.

Pairs are formed across the rotation, not per converter. In dual mode every word therefore holds the first converter in the low byte and the second converter in the high byte. In triple mode the converter pair changes from word to word with a period of three words. An overrun on any converter taking part, or a new pair that completes while a request is still pending, stops all further requests. Only data known to be good then reaches memory. Dropping the enable or pulsing the restart input clears the stop, the pending request and the pair phase.

Top module: `adc_pair_packer`

## Requirements
- R1: In dual mode (triple_i=0) the rotation is converter 0 then converter 1, and every packed word has converter 1's byte in cdr_o[15:8] and converter 0's byte in cdr_o[7:0].
- R2: In triple mode (triple_i=1) the rotation is converters 0, 1, 2. The packed words repeat with period three as (hi=1, lo=0), (hi=0, lo=2), (hi=2, lo=1), and then return to the first pattern.
- R3: When res6_i=1, bits [7:6] of each accepted byte are forced to zero before packing, so bits 7:6 and 15:14 of cdr_o are zero.
- R4: dma_req_o rises, with cdr_o holding the new word, in the first cycle after the clock edge that accepts the second result of a pair. It stays high until dma_ack_i is sampled high, and it is low in the cycle after that edge.
- R5: An overrun flag seen on converter 0 or 1, or on converter 2 in triple mode only, blocks every later request until the block is cleared. An overrun flag on converter 2 in dual mode has no effect.
- R6: If a pair completes while a request is pending and dma_ack_i is low in that cycle, the new word is dropped and the block becomes blocked. The pending word stays on cdr_o and its request stays high until it is acknowledged.
- R7: A valid strobe from a converter that is not next in the rotation is ignored. It neither fills a pair nor advances the rotation.
- R8: When en_i is low or restart_i is high, the request and the blocked state are cleared, the rotation returns to converter 0 and the pair phase returns to the first pattern, all at the next clock edge.
- R9: After reset dma_req_o is 0 and cdr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Packing enable; low clears the block's state |
| restart_i | input | 1 | Synchronous restart pulse |
| triple_i | input | 1 | 1 = three converters, 0 = two converters |
| res6_i | input | 1 | 1 = 6-bit results, zero-extended to 8 bits |
| valid_i | input | 3 | Per-converter result strobe |
| ovr_i | input | 3 | Per-converter overrun flag |
| data_i | input | 24 | Per-converter result; converter k on bits [8k+7:8k] |
| dma_ack_i | input | 1 | DMA acknowledge; clears the pending request |
| cdr_o | output | 16 | Packed common data word |
| dma_req_o | output | 1 | DMA request |

## Verification
The assertions check several properties on every cycle. A request is held until it is acknowledged, and it is cleared after an acknowledge when no new result arrives. The output word does not change while a request is pending. Enable or restart clears the block. An overrun on converter 0 or 1 always blocks, and once blocked no new request appears. Newly packed words in 6-bit mode have their top bits clear. The byte placement, the three-word rotation in triple mode, the rejection of out-of-turn strobes, the dual-mode immunity to converter 2's overrun and the collision case depend on the history of the stream. These only show in the bench's scenarios, where a behavioural queue model is compared against the outputs on every clock.

// File: rtl/adc_pack_pkg.sv
package adc_pack_pkg;
  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } pair_phase_e;
endpackage

// File: rtl/rr_tracker.sv
module rr_tracker
  import adc_pack_pkg::*;
#(
  parameter int unsigned N_CONV = 3,
  localparam int unsigned PTR_W = (N_CONV > 1) ? $clog2(N_CONV) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             triple_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o,
  output pair_phase_e      phase_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] last_idx;
  pair_phase_e      phase_q;

  assign last_idx = triple_i ? PTR_W'(N_CONV - 1) : PTR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      phase_q <= PH_FIRST;
    end else if (clr_i) begin
      ptr_q   <= '0;
      phase_q <= PH_FIRST;
    end else if (adv_i) begin
      ptr_q   <= (ptr_q == last_idx) ? '0 : ptr_q + PTR_W'(1);
      phase_q <= (phase_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
    end
  end

  assign ptr_o   = ptr_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/byte_stager.sv
module byte_stager #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LOW_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res6_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              load_lo_i,
  input  logic              load_word_i,
  output logic [2*DATA_W-1:0] word_o
);
  localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-LOW_W){1'b0}}, {LOW_W{1'b1}}};

  logic [DATA_W-1:0]   byte_m;
  logic [DATA_W-1:0]   stage_q;
  logic [2*DATA_W-1:0] word_q;

  assign byte_m = res6_i ? (byte_i & LOW_MASK) : byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      word_q  <= '0;
    end else begin
      if (load_lo_i)   stage_q <= byte_m;
      if (load_word_i) word_q  <= {byte_m, stage_q};
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/req_ctrl.sv
module req_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic pair_i,
  input  logic ovr_hit_i,
  input  logic ack_i,
  output logic store_o,
  output logic req_o,
  output logic blocked_o
);
  logic req_q, blk_q, collide;

  // a finished pair with an unacknowledged word still pending is an overrun
  assign collide = pair_i & req_q & ~ack_i;
  assign store_o = pair_i & ~ovr_hit_i & ~collide & ~blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      blk_q <= 1'b0;
    end else if (clr_i) begin
      req_q <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      if (store_o)    req_q <= 1'b1;
      else if (ack_i) req_q <= 1'b0;
      if (ovr_hit_i || collide) blk_q <= 1'b1;
    end
  end

  assign req_o     = req_q;
  assign blocked_o = blk_q;
endmodule

// File: rtl/adc_pair_packer.sv
module adc_pair_packer
  import adc_pack_pkg::*;
#(
  parameter int unsigned N_CONV = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LOW_W  = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     restart_i,
  input  logic                     triple_i,
  input  logic                     res6_i,
  input  logic [N_CONV-1:0]        valid_i,
  input  logic [N_CONV-1:0]        ovr_i,
  input  logic [N_CONV*DATA_W-1:0] data_i,
  input  logic                     dma_ack_i,
  output logic [2*DATA_W-1:0]      cdr_o,
  output logic                     dma_req_o
);
  localparam int unsigned PTR_W = (N_CONV > 1) ? $clog2(N_CONV) : 1;
  localparam int unsigned SLOTS = 2 ** PTR_W;

  logic [PTR_W-1:0]  ptr;
  pair_phase_e       phase;
  logic [DATA_W-1:0] slot_data [SLOTS];
  logic [SLOTS-1:0]  slot_valid;
  logic [N_CONV-1:0] part_mask;
  logic clr, blocked, accept, pair, store, ovr_hit;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (k < N_CONV) begin : g_used
      assign slot_data[k]  = data_i[k*DATA_W +: DATA_W];
      assign slot_valid[k] = valid_i[k];
    end else begin : g_pad
      assign slot_data[k]  = '0;
      assign slot_valid[k] = 1'b0;
    end
  end

  // converters beyond the second take part only in triple mode
  for (genvar k = 0; k < N_CONV; k++) begin : g_part
    if (k < 2) begin : g_base
      assign part_mask[k] = 1'b1;
    end else begin : g_ext
      assign part_mask[k] = triple_i;
    end
  end

  assign clr     = ~en_i | restart_i;
  assign ovr_hit = ~clr & |(ovr_i & part_mask);
  assign accept  = ~clr & ~blocked & slot_valid[ptr];
  assign pair    = accept & (phase == PH_SECOND);

  rr_tracker #(.N_CONV(N_CONV)) u_rr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .triple_i (triple_i),
    .adv_i    (accept),
    .ptr_o    (ptr),
    .phase_o  (phase)
  );

  byte_stager #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .res6_i      (res6_i),
    .byte_i      (slot_data[ptr]),
    .load_lo_i   (accept & (phase == PH_FIRST)),
    .load_word_i (store),
    .word_o      (cdr_o)
  );

  req_ctrl u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .pair_i    (pair),
    .ovr_hit_i (ovr_hit),
    .ack_i     (dma_ack_i),
    .store_o   (store),
    .req_o     (dma_req_o),
    .blocked_o (blocked)
  );
endmodule

// File: rtl/adc_pair_packer_chk.sv
module adc_pair_packer_chk #(
  parameter int unsigned N_CONV = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LOW_W  = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                en_i,
  input logic                restart_i,
  input logic                res6_i,
  input logic [N_CONV-1:0]   valid_i,
  input logic [N_CONV-1:0]   ovr_i,
  input logic                dma_ack_i,
  input logic                dma_req_o,
  input logic [2*DATA_W-1:0] cdr_o,
  input logic                blocked
);
  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o && !dma_ack_i && en_i && !restart_i |=> dma_req_o);

  p_ack_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o && dma_ack_i && (valid_i == '0) |=> !dma_req_o);

  p_cdr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o && !dma_ack_i |=> $stable(cdr_o));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || restart_i) |=> !dma_req_o && !blocked);

  p_ovr_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !restart_i && (ovr_i[0] || ovr_i[1]) |=> blocked);

  p_no_new_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked && en_i && !restart_i && !dma_req_o |=> !dma_req_o);

  p_zext_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_req_o) && $past(res6_i) |->
      (cdr_o[DATA_W-1:LOW_W] == '0) && (cdr_o[2*DATA_W-1:DATA_W+LOW_W] == '0));
endmodule

bind adc_pair_packer adc_pair_packer_chk #(
  .N_CONV(N_CONV), .DATA_W(DATA_W), .LOW_W(LOW_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .restart_i (restart_i),
  .res6_i    (res6_i),
  .valid_i   (valid_i),
  .ovr_i     (ovr_i),
  .dma_ack_i (dma_ack_i),
  .dma_req_o (dma_req_o),
  .cdr_o     (cdr_o),
  .blocked   (blocked)
);

// File: tb/adc_pair_packer_tb_top.sv
`timescale 1ns/1ps
module adc_pair_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0, restart_i = 1'b0, triple_i = 1'b0, res6_i = 1'b0;
  logic [2:0]  valid_i = '0, ovr_i = '0;
  logic [23:0] data_i = '0;
  logic        dma_ack_i = 1'b0;
  logic [15:0] cdr_o;
  logic        dma_req_o;

  int checks = 0, errors = 0;
  string cur_r = "R9";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_pair_packer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_i), .restart_i(restart_i),
    .triple_i(triple_i), .res6_i(res6_i), .valid_i(valid_i), .ovr_i(ovr_i),
    .data_i(data_i), .dma_ack_i(dma_ack_i), .cdr_o(cdr_o), .dma_req_o(dma_req_o)
  );

  // behavioural reference model
  logic [7:0]  q[$];
  int          m_next = 0;
  bit          m_req = 0, m_blk = 0;
  logic [15:0] m_cdr = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_next = 0; m_req = 0; m_blk = 0; m_cdr = '0;
    end else if (!en_i || restart_i) begin
      q.delete(); m_next = 0; m_req = 0; m_blk = 0;
    end else begin
      int  n;
      bit  ovr, pair, collide;
      logic [7:0] b, lo, hi;
      n    = triple_i ? 3 : 2;
      ovr  = ovr_i[0] || ovr_i[1] || (triple_i && ovr_i[2]);
      pair = 0;
      if (!m_blk && valid_i[m_next]) begin
        b = data_i[m_next*8 +: 8];
        if (res6_i) b = b & 8'h3f;
        q.push_back(b);
        m_next = (m_next + 1) % n;
        if (q.size() == 2) pair = 1;
      end
      collide = pair && m_req && !dma_ack_i;
      if (pair) begin
        lo = q.pop_front();
        hi = q.pop_front();
      end
      if (pair && !ovr && !collide) begin
        m_cdr = {hi, lo};
        m_req = 1;
      end else if (dma_ack_i) begin
        m_req = 0;
      end
      if (ovr || collide) m_blk = 1;
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_r, " model req"}, {31'd0, dma_req_o}, {31'd0, m_req});
      chk({cur_r, " model cdr"}, {16'd0, cdr_o}, {16'd0, m_cdr});
    end
  end

  task automatic feed(int k, logic [7:0] v);
    valid_i[k] = 1'b1;
    data_i[k*8 +: 8] = v;
    @(negedge clk);
    valid_i = '0;
  endtask

  task automatic ack();
    dma_ack_i = 1'b1;
    @(negedge clk);
    dma_ack_i = 1'b0;
  endtask

  task automatic restart();
    restart_i = 1'b1;
    @(negedge clk);
    restart_i = 1'b0;
  endtask

  task automatic ovr_pulse(int k);
    ovr_i[k] = 1'b1;
    @(negedge clk);
    ovr_i = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset req", {31'd0, dma_req_o}, 0);
    chk("R9 reset cdr", {16'd0, cdr_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    en_i = 1'b1;
    @(negedge clk);

    cur_r = "R1";
    feed(0, 8'h11); feed(1, 8'h22);
    chk("R1 req", {31'd0, dma_req_o}, 1);
    chk("R1 word", {16'd0, cdr_o}, 32'h2211);
    ack();
    chk("R4 ack clears", {31'd0, dma_req_o}, 0);
    feed(0, 8'h33); feed(1, 8'h44);
    chk("R1 word2", {16'd0, cdr_o}, 32'h4433);
    ack();

    cur_r = "R4";
    feed(0, 8'h55); feed(1, 8'h66);
    repeat (3) @(negedge clk);
    chk("R4 held", {31'd0, dma_req_o}, 1);
    chk("R4 word", {16'd0, cdr_o}, 32'h6655);
    ack();
    chk("R4 cleared", {31'd0, dma_req_o}, 0);

    cur_r = "R7";
    feed(1, 8'h77);
    chk("R7 ignored req", {31'd0, dma_req_o}, 0);
    feed(0, 8'h88); feed(1, 8'h99);
    chk("R7 word", {16'd0, cdr_o}, 32'h9988);
    ack();

    cur_r = "R3";
    res6_i = 1'b1;
    feed(0, 8'hff); feed(1, 8'hc5);
    chk("R3 zero-ext", {16'd0, cdr_o}, 32'h053f);
    ack();
    res6_i = 1'b0;

    cur_r = "R2";
    restart();
    triple_i = 1'b1;
    feed(0, 8'ha1); feed(1, 8'hb2);
    chk("R2 word1", {16'd0, cdr_o}, 32'hb2a1);
    ack();
    feed(2, 8'hc3); feed(0, 8'hd4);
    chk("R2 word2", {16'd0, cdr_o}, 32'hd4c3);
    ack();
    feed(1, 8'he5); feed(2, 8'hf6);
    chk("R2 word3", {16'd0, cdr_o}, 32'hf6e5);
    ack();
    feed(0, 8'h17); feed(1, 8'h28);
    chk("R2 wrap", {16'd0, cdr_o}, 32'h2817);
    ack();

    cur_r = "R5";
    restart();
    triple_i = 1'b0;
    ovr_pulse(2);
    feed(0, 8'h31); feed(1, 8'h42);
    chk("R5 dual ignores conv2 ovr", {31'd0, dma_req_o}, 1);
    chk("R5 word", {16'd0, cdr_o}, 32'h4231);
    ack();
    ovr_pulse(1);
    feed(0, 8'h53); feed(1, 8'h64);
    chk("R5 blocked req", {31'd0, dma_req_o}, 0);
    chk("R5 blocked cdr", {16'd0, cdr_o}, 32'h4231);

    cur_r = "R8";
    en_i = 1'b0;
    @(negedge clk);
    en_i = 1'b1;
    feed(0, 8'h75); feed(1, 8'h86);
    chk("R8 unblocked", {31'd0, dma_req_o}, 1);
    chk("R8 word", {16'd0, cdr_o}, 32'h8675);
    restart();
    chk("R8 restart clears req", {31'd0, dma_req_o}, 0);

    cur_r = "R6";
    feed(0, 8'h01); feed(1, 8'h02);
    feed(0, 8'h03); feed(1, 8'h04);
    chk("R6 pending kept", {31'd0, dma_req_o}, 1);
    chk("R6 word kept", {16'd0, cdr_o}, 32'h0201);
    ack();
    chk("R6 ack", {31'd0, dma_req_o}, 0);
    feed(0, 8'h05); feed(1, 8'h06);
    chk("R6 blocked", {31'd0, dma_req_o}, 0);

    cur_r = "R5";
    restart();
    triple_i = 1'b1;
    ovr_pulse(2);
    feed(0, 8'h09); feed(1, 8'h0a);
    chk("R5 triple conv2 ovr blocks", {31'd0, dma_req_o}, 0);

    @(negedge clk);
    finish_run();
  end
endmodule